// File: doc/BRIEF.md
# Strobe-Accessed ROM and Dual Port Expander

This block sits on a narrow host bus and offers three resources behind one 8-bit bidirectional data bus: a read-only byte array, a 16-bit address counter that the host loads one byte at a time, and two 8-bit bidirectional expansion ports. Each port has an output register and a direction register. The host drives an active-low chip select, an active-low write strobe, an active-low read enable and a 3-bit register select. The array contents come from a constant function, so no memory file is needed.

The strobes arrive with no relation to the block clock. They pass through two-flop synchronizers and edge detectors, so every register lives in the single `clk` domain. Data and select are synchronized alongside the strobes and stay aligned with them. The data bus is driven combinationally from the pins while read is active. A sequential read returns the array byte at the counter and advances the counter when the read enable rises. A second select code reads the array without moving the counter. Deselecting the chip freezes every register, while the ports keep driving whatever they drove before.

Top module: `strobe_rom_expander`

## Requirements
- R1: While `chip_sel_n` is high, strobes change no register. The address counter, the output registers and the direction registers keep their values, and port pins that were driven keep their levels.
- R2: When `wr_stb_n` rises with the chip selected, the value on `bus` is latched into the register named by `reg_sel`: 1 = counter bits 7..0, 2 = counter bits 15..8, 3 = port A output, 4 = port A direction, 5 = port B output, 6 = port B direction. Writes with select 0 or 7 change nothing. The new value can be read back within a few clocks.
- R3: A read with select 1 returns the counter's low byte, and a read with select 2 returns its high byte.
- R4: A read with select 0 returns the array byte at the counter, and the counter then advances by one when `rd_en_n` rises. The byte at address A is ((A[7:0]*29) mod 256) XOR ((A[15:8] + 0x5A) mod 256).
- R5: `bus` is not driven while `chip_sel_n` is high or `rd_en_n` is high.
- R6: A read with select 7 returns the array byte at the counter and leaves the counter unchanged.
- R7: The counter wraps from 0xFFFF to 0x0000 on a sequential read.
- R8: After reset the counter, both output registers and both direction registers are zero, and `bus` is released.
- R9: A direction bit of 1 drives that pin from the output register bit, and a bit of 0 releases the pin. A read with select 3 (port A) or 5 (port B) returns the actual pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_stb_n | input | 1 | Active-low write strobe; latches on its rising edge |
| rd_en_n | input | 1 | Active-low read enable; drives the bus while low |
| reg_sel | input | 3 | Register select code |
| bus | inout | 8 | Host data bus |
| port_a | inout | 8 | Expansion port A pins |
| port_b | inout | 8 | Expansion port B pins |

## Verification
A counter that is off by one shows up on the very next select-0 or select-7 read as a wrong array byte. The bench picks array values that differ at neighbouring addresses and across the carry into the high byte, so a missed or doubled step cannot pass unnoticed. A direction or output register that took a write while deselected, or that lost its value, shows at once on the port pins and on the next register read-back. A bus enable that is stuck on corrupts a known value the bench drives onto `bus` during the same cycle.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    SEL_ROM_INC  = 3'd0,
    SEL_ADR_LO   = 3'd1,
    SEL_ADR_HI   = 3'd2,
    SEL_PA_DAT   = 3'd3,
    SEL_PA_DIR   = 3'd4,
    SEL_PB_DAT   = 3'd5,
    SEL_PB_DIR   = 3'd6,
    SEL_ROM_HOLD = 3'd7
  } srx_sel_e;

  // Array content: byte at address a, folded down from a 32-bit view.
  function automatic logic [7:0] rom_byte(input logic [31:0] a, input logic [7:0] seed);
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] mix;
    lo  = a[7:0];
    hi  = a[15:8] ^ a[23:16] ^ a[31:24];
    mix = 8'(lo * 8'd29);
    return mix ^ 8'(hi + seed);
  endfunction

  function automatic logic is_rom_sel(input srx_sel_e s);
    return (s == SEL_ROM_INC) || (s == SEL_ROM_HOLD);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_addr_ctr.sv
module srx_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              step,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_lo) begin
      addr[7:0] <= din;
    end else if (ld_hi) begin
      addr[ADDR_W-1:8] <= HI_W'(din);
    end else if (step) begin
      addr <= next_addr(addr);
    end
  end
endmodule

// File: rtl/srx_port.sv
module srx_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_out,
  input  logic         wr_dir,
  input  logic [W-1:0] din,
  inout  wire  [W-1:0] pins,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pin_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_out) out_q <= din;
      if (wr_dir) dir_q <= din;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pins[i] = dir_q[i] ? out_q[i] : 1'bz;
  end

  assign pin_lvl = pins;
endmodule

// File: rtl/strobe_rom_expander.sv
module strobe_rom_expander
  import srx_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ROM_SEED    = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_sel_n,
  input  logic       wr_stb_n,
  input  logic       rd_en_n,
  input  logic [2:0] reg_sel,
  inout  wire  [7:0] bus,
  inout  wire  [7:0] port_a,
  inout  wire  [7:0] port_b
);
  localparam int BW    = 8;
  localparam int SEL_W = 3;
  localparam int CTX_W = SEL_W + BW;

  // Synchronized strobes: [2]=select, [1]=write, [0]=read
  logic [2:0]       strb_s;
  logic [SEL_W-1:0] sel_bits_s;
  logic [BW-1:0]    din_s;
  srx_sel_e         sel_s;

  srx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({chip_sel_n, wr_stb_n, rd_en_n}),
    .q     (strb_s)
  );

  srx_sync #(.W(CTX_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ctx_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({reg_sel, bus}),
    .q     ({sel_bits_s, din_s})
  );

  assign sel_s = srx_sel_e'(sel_bits_s);

  // Edge detection on synchronized strobes
  logic wr_q, rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= strb_s[1];
      rd_q <= strb_s[0];
    end
  end

  // Named internal events
  logic wr_rise, rd_rise, acc_ok, wr_evt, rd_evt;
  assign wr_rise = strb_s[1] & ~wr_q;
  assign rd_rise = strb_s[0] & ~rd_q;
  assign acc_ok  = ~strb_s[2];
  assign wr_evt  = wr_rise & acc_ok;
  assign rd_evt  = rd_rise & acc_ok;

  // Write decode
  logic ld_lo, ld_hi, seq_step;
  logic wr_pa_dat, wr_pa_dir, wr_pb_dat, wr_pb_dir;
  assign ld_lo     = wr_evt && (sel_s == SEL_ADR_LO);
  assign ld_hi     = wr_evt && (sel_s == SEL_ADR_HI);
  assign wr_pa_dat = wr_evt && (sel_s == SEL_PA_DAT);
  assign wr_pa_dir = wr_evt && (sel_s == SEL_PA_DIR);
  assign wr_pb_dat = wr_evt && (sel_s == SEL_PB_DAT);
  assign wr_pb_dir = wr_evt && (sel_s == SEL_PB_DIR);
  assign seq_step  = rd_evt && (sel_s == SEL_ROM_INC);

  logic [ADDR_W-1:0] addr;
  srx_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .step  (seq_step),
    .din   (din_s),
    .addr  (addr)
  );

  logic [BW-1:0] pa_out, pa_dir, pa_lvl;
  logic [BW-1:0] pb_out, pb_dir, pb_lvl;

  srx_port #(.W(BW)) u_port_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_out  (wr_pa_dat),
    .wr_dir  (wr_pa_dir),
    .din     (din_s),
    .pins    (port_a),
    .out_q   (pa_out),
    .dir_q   (pa_dir),
    .pin_lvl (pa_lvl)
  );

  srx_port #(.W(BW)) u_port_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_out  (wr_pb_dat),
    .wr_dir  (wr_pb_dir),
    .din     (din_s),
    .pins    (port_b),
    .out_q   (pb_out),
    .dir_q   (pb_dir),
    .pin_lvl (pb_lvl)
  );

  // Read path: combinational from the live select pins
  logic [BW-1:0] rom_val, rd_val;
  srx_sel_e      sel_live;
  assign sel_live = srx_sel_e'(reg_sel);
  assign rom_val  = rom_byte(32'(addr), ROM_SEED);

  always_comb begin
    rd_val = '0;
    if (is_rom_sel(sel_live)) begin
      rd_val = rom_val;
    end else begin
      case (sel_live)
        SEL_ADR_LO: rd_val = addr[7:0];
        SEL_ADR_HI: rd_val = BW'(addr >> 8);
        SEL_PA_DAT: rd_val = pa_lvl;
        SEL_PA_DIR: rd_val = pa_dir;
        SEL_PB_DAT: rd_val = pb_lvl;
        SEL_PB_DIR: rd_val = pb_dir;
        default:    rd_val = rom_val;
      endcase
    end
  end

  logic bus_oe;
  assign bus_oe = ~chip_sel_n & ~rd_en_n;
  assign bus    = bus_oe ? rd_val : 'z;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sel_n,
  input logic              rd_en_n,
  input logic              acc_ok,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic [2:0]        sel_s,
  input logic [7:0]        din_s,
  input logic              bus_oe,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        pa_out,
  input logic [7:0]        pa_dir,
  input logic [7:0]        pb_out,
  input logic [7:0]        pb_dir
);
  AST_DESEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> ($stable(addr) && $stable(pa_out) && $stable(pa_dir)
                 && $stable(pb_out) && $stable(pb_dir))); // R1

  AST_DIR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && sel_s == 3'd4) |=> (pa_dir == $past(din_s))); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && sel_s == 3'd0) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R4

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n || rd_en_n) |-> !bus_oe); // R5

  AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && sel_s == 3'd7) |=> $stable(addr)); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && sel_s == 3'd0 && addr == '1) |=> (addr == '0)); // R7
endmodule

bind strobe_rom_expander srx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_sel_n (chip_sel_n),
  .rd_en_n    (rd_en_n),
  .acc_ok     (acc_ok),
  .wr_evt     (wr_evt),
  .rd_evt     (rd_evt),
  .sel_s      (sel_bits_s),
  .din_s      (din_s),
  .bus_oe     (bus_oe),
  .addr       (addr),
  .pa_out     (pa_out),
  .pa_dir     (pa_dir),
  .pb_out     (pb_out),
  .pb_dir     (pb_dir)
);

// File: tb/strobe_rom_expander_test.sv
module strobe_rom_expander_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_sel_n = 1'b1;
  logic       wr_stb_n = 1'b1;
  logic       rd_en_n = 1'b1;
  logic [2:0] reg_sel = 3'd0;
  wire  [7:0] bus;
  wire  [7:0] port_a;
  wire  [7:0] port_b;

  logic       tb_drv = 1'b0;
  logic [7:0] tb_dat = 8'h00;
  logic [7:0] pa_en = 8'h00;
  logic [7:0] pa_val = 8'h00;

  assign bus = tb_drv ? tb_dat : 'z;
  for (genvar i = 0; i < 8; i++) begin : g_pa_drv
    assign port_a[i] = pa_en[i] ? pa_val[i] : 1'bz;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_rom_expander uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .wr_stb_n   (wr_stb_n),
    .rd_en_n    (rd_en_n),
    .reg_sel    (reg_sel),
    .bus        (bus),
    .port_a     (port_a),
    .port_b     (port_b)
  );

  typedef struct {
    int         src;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  event  sample_ev;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // Array content restated with shifts and adds
  function automatic logic [7:0] exp_rom(input int a);
    int lo, hi, m;
    lo = a & 255;
    hi = (a >> 8) & 255;
    m  = ((lo << 4) + (lo << 3) + (lo << 2) + lo) & 255;
    return 8'(m ^ ((hi + 'h5A) & 255));
  endfunction

  // Monitor: pops expected items and compares with the live signal
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.src)
          0:       act = bus;
          1:       act = port_a;
          default: act = port_b;
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s src=%0d actual=%02h expected=%02h", it.req, it.src, act, it.exp);
        end
      end
    end
  end

  task automatic expect_now(input int src, input logic [7:0] exp, input string req);
    sb.push_back('{src: src, exp: exp, req: req});
    -> sample_ev;
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val, input logic csn);
    @(negedge clk);
    reg_sel = sel; tb_dat = val; tb_drv = 1'b1; chip_sel_n = csn;
    repeat (2) @(negedge clk);
    wr_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_stb_n = 1'b1;
    repeat (5) @(negedge clk);
    tb_drv = 1'b0; chip_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] sel, input logic [7:0] exp, input string req,
                        input logic csn, input bit chk);
    @(negedge clk);
    reg_sel = sel; chip_sel_n = csn;
    @(negedge clk);
    rd_en_n = 1'b0;
    repeat (3) @(negedge clk);
    if (chk) expect_now(0, exp, req);
    rd_en_n = 1'b1;
    repeat (6) @(negedge clk);
    chip_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset values
    rd_reg(3'd4, 8'h00, "R8 pa_dir", 1'b0, 1'b1);
    rd_reg(3'd6, 8'h00, "R8 pb_dir", 1'b0, 1'b1);
    rd_reg(3'd1, 8'h00, "R8 addr_lo", 1'b0, 1'b1);
    rd_reg(3'd2, 8'h00, "R8 addr_hi", 1'b0, 1'b1);
    rd_reg(3'd7, exp_rom(0), "R8 rom0", 1'b0, 1'b1);

    // R3: counter load and read-back
    wr_reg(3'd1, 8'hFE, 1'b0);
    wr_reg(3'd2, 8'h12, 1'b0);
    rd_reg(3'd1, 8'hFE, "R3 lo", 1'b0, 1'b1);
    rd_reg(3'd2, 8'h12, "R3 hi", 1'b0, 1'b1);

    // R4: sequential reads with carry into high byte
    rd_reg(3'd0, exp_rom('h12FE), "R4 seq0", 1'b0, 1'b1);
    rd_reg(3'd0, exp_rom('h12FF), "R4 seq1", 1'b0, 1'b1);
    rd_reg(3'd0, exp_rom('h1300), "R4 seq2", 1'b0, 1'b1);

    // R6: hold reads do not move the counter
    rd_reg(3'd7, exp_rom('h1301), "R6 hold0", 1'b0, 1'b1);
    rd_reg(3'd7, exp_rom('h1301), "R6 hold1", 1'b0, 1'b1);
    rd_reg(3'd0, exp_rom('h1301), "R6 seq after hold", 1'b0, 1'b1);

    // R7: wrap from top address
    wr_reg(3'd1, 8'hFF, 1'b0);
    wr_reg(3'd2, 8'hFF, 1'b0);
    rd_reg(3'd0, exp_rom('hFFFF), "R7 top", 1'b0, 1'b1);
    rd_reg(3'd1, 8'h00, "R7 lo wrapped", 1'b0, 1'b1);
    rd_reg(3'd2, 8'h00, "R7 hi wrapped", 1'b0, 1'b1);

    // R9 / R2: port A mixed direction
    pa_en = 8'h0F; pa_val = 8'h03;
    wr_reg(3'd3, 8'hA5, 1'b0);
    wr_reg(3'd4, 8'hF0, 1'b0);
    rd_reg(3'd3, 8'hA3, "R9 pa pins read", 1'b0, 1'b1);
    expect_now(1, 8'hA3, "R9 pa pin levels");
    rd_reg(3'd4, 8'hF0, "R2 pa_dir", 1'b0, 1'b1);

    // R9: port B all outputs
    wr_reg(3'd5, 8'h3C, 1'b0);
    wr_reg(3'd6, 8'hFF, 1'b0);
    expect_now(2, 8'h3C, "R9 pb pin levels");
    rd_reg(3'd5, 8'h3C, "R9 pb read", 1'b0, 1'b1);
    rd_reg(3'd6, 8'hFF, "R2 pb_dir", 1'b0, 1'b1);

    // R1: deselected accesses are ignored
    wr_reg(3'd4, 8'hFF, 1'b1);
    wr_reg(3'd1, 8'h77, 1'b1);
    wr_reg(3'd6, 8'h00, 1'b1);
    rd_reg(3'd0, 8'h00, "R1 desel read", 1'b1, 1'b0);
    rd_reg(3'd4, 8'hF0, "R1 pa_dir kept", 1'b0, 1'b1);
    rd_reg(3'd1, 8'h00, "R1 counter kept", 1'b0, 1'b1);
    expect_now(2, 8'h3C, "R1 pb still driven");

    // R2: writes with select 0 or 7 change nothing
    wr_reg(3'd0, 8'h99, 1'b0);
    wr_reg(3'd7, 8'h55, 1'b0);
    rd_reg(3'd1, 8'h00, "R2 sel0/7 write lo", 1'b0, 1'b1);
    rd_reg(3'd2, 8'h00, "R2 sel0/7 write hi", 1'b0, 1'b1);

    // R5: bus released when deselected or read enable high
    wr_reg(3'd1, 8'h01, 1'b0);
    @(negedge clk);
    reg_sel = 3'd7; tb_dat = 8'h00; tb_drv = 1'b1;
    chip_sel_n = 1'b1; rd_en_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_now(0, 8'h00, "R5 deselected");
    rd_en_n = 1'b1; chip_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_now(0, 8'h00, "R5 read enable high");
    chip_sel_n = 1'b1; tb_drv = 1'b0;
    repeat (4) @(negedge clk);
    rd_reg(3'd7, exp_rom(1), "R5 bus driven on read", 1'b0, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule